// File: doc/BRIEF.md
# Adaptive Peak-Current Code Controller

This block selects the 3-bit peak-current code for a switching regulator. A load meter outside the block delivers a percentage reading on a 7-bit input with a one-cycle valid strobe. When the meter path is enabled, each reading is latched and reported. When adaptive operation is enabled, the block compares each usable reading against a programmable low and high threshold. It steps its own code up when the load is heavy and down when the load is light. A spacing rule keeps the code from hunting.

With adaptive operation off, the code that software programs on `sw_code` passes straight through to the regulator. When adaptive operation is switched on, the hardware code starts from that software value. A single configuration word holds the meter enable, the adaptive enable and the two thresholds. A status word shows the code in force and the last latched reading.

Top module: `peak_code_tuner`

## Requirements
- R1: The configuration word resets to 0. A write on `cfg_we` stores meter enable in bit 0, adaptive enable in bit 4, the low threshold in bits 14:8 and the high threshold in bits 22:16. `cfg_rdata` returns these fields in the same positions, and every other bit reads 0.
- R2: `status_word` carries the applied code in bits 10:8 and the latched load reading in bits 6:0. All other bits are 0, and the word is 0 after reset.
- R3: A reading is latched at a clock edge only when `load_valid` is high and meter enable is set. Otherwise the latched value holds. It resets to 0.
- R4: With adaptive enable clear, `applied_code` and status bits 10:8 equal `sw_code` in the same cycle.
- R5: With adaptive enable set, a usable sample that may step works as follows. A load strictly above the high threshold raises the code by one, saturating at 7. A load strictly below the low threshold lowers it by one, saturating at 0. Any other load holds the code. The new code shows just after the sampling edge.
- R6: A threshold of 0 or above 100 switches off its own comparison. The other comparison stays active.
- R7: When both thresholds are in 1..100 and the low threshold exceeds the high threshold, no sample changes the code.
- R8: At the first cycle with adaptive enable set, the applied code equals the `sw_code` value from the cycle before.
- R9: After a step, the next STEP_GAP-1 usable samples cannot step. Usable samples that do not step advance the spacing count, which saturates.
- R10: A sample is usable only when the meter is enabled, `load_valid` is high and the reading lies in 1..100. Readings of 0 or 101..127 are still latched for status, but they neither step the code nor advance the spacing count.
- R11: While adaptive enable is clear, the spacing count is held full. The first usable sample after enabling may therefore step at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_wdata | input | 32 | Configuration write data |
| cfg_rdata | output | 32 | Configuration word as stored |
| sw_code | input | 3 | Software-programmed peak-current code |
| load_valid | input | 1 | Load reading strobe |
| load_pct | input | 7 | Load reading in percent |
| status_word | output | 32 | Applied code and latched load |
| applied_code | output | 3 | Code driven to the regulator |

## Verification
The bench builds the block with STEP_GAP set to 3. With that value, one step followed by two blocked samples, and then a second step, all fit in a handful of vectors. The full climb to 7 and the descent to 0 need only a few dozen samples, so both saturation ends are reached. The remaining phases cover several cases. One disables each threshold with 0 and with values above 100. Another inverts the thresholds to freeze the code. Others feed readings of 0 and above 100, and toggle adaptive mode to show the restart from the software code with an immediate first step.

// File: rtl/ptune_pkg.sv
// Shared widths, field positions and helpers for the peak-code tuner.
// Assumes a 7-bit percentage scale where only 1..100 carry meaning.
package ptune_pkg;
    localparam int PCT_W       = 7;
    localparam int CODE_W      = 3;
    localparam int PCT_MAX     = 100;
    localparam int CFG_MTR_BIT = 0;
    localparam int CFG_ADP_BIT = 4;
    localparam int CFG_LO_LSB  = 8;
    localparam int CFG_HI_LSB  = 16;
    localparam int ST_CODE_LSB = 8;

    typedef struct packed {
        logic [PCT_W-1:0] hi_thr;
        logic [PCT_W-1:0] lo_thr;
        logic             adapt_en;
        logic             mtr_en;
    } tune_cfg_t;

    // True when a percentage value lies in the meaningful range 1..100.
    function automatic logic pct_in_range(input logic [PCT_W-1:0] v);
        return (v != '0) && (v <= PCT_W'(PCT_MAX));
    endfunction
endpackage

// File: rtl/ptune_cfg_reg.sv
// Configuration register: stores the enable bits and both thresholds.
// Assumes one write per strobe; unused bit positions are dropped on write.
module ptune_cfg_reg
    import ptune_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        we,
    input  logic [31:0] wdata,
    output tune_cfg_t   cfg,
    output logic [31:0] rdata
);
    // Capture the written fields, clear on reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg <= '0;
        end else if (we) begin
            cfg.mtr_en   <= wdata[CFG_MTR_BIT];
            cfg.adapt_en <= wdata[CFG_ADP_BIT];
            cfg.lo_thr   <= wdata[CFG_LO_LSB +: PCT_W];
            cfg.hi_thr   <= wdata[CFG_HI_LSB +: PCT_W];
        end
    end

    // Rebuild the word with the fields in their fixed positions.
    always_comb begin
        rdata = '0;
        rdata[CFG_MTR_BIT]            = cfg.mtr_en;
        rdata[CFG_ADP_BIT]            = cfg.adapt_en;
        rdata[CFG_LO_LSB +: PCT_W]    = cfg.lo_thr;
        rdata[CFG_HI_LSB +: PCT_W]    = cfg.hi_thr;
    end
endmodule

// File: rtl/ptune_load_latch.sv
// Latches load readings while the meter path is enabled and flags the
// readings that may drive adaptation (in range 1..100).
module ptune_load_latch
    import ptune_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             mtr_en,
    input  logic             load_valid,
    input  logic [PCT_W-1:0] load_pct,
    output logic [PCT_W-1:0] load_q,
    output logic             sample_ok
);
    logic take;
    assign take      = load_valid && mtr_en;
    assign sample_ok = take && pct_in_range(load_pct);

    // Hold the last accepted reading for status.
    always_ff @(posedge clk) begin
        if (!rst_n)    load_q <= '0;
        else if (take) load_q <= load_pct;
    end

    p_meter_off_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!(load_valid && mtr_en)) |=> $stable(load_q));
endmodule

// File: rtl/ptune_step_engine.sv
// Hysteretic code stepper. It tracks the software code while adaptive mode
// is off. In adaptive mode it moves one step per usable sample, subject to
// the thresholds and a spacing of STEP_GAP samples between steps.
module ptune_step_engine
    import ptune_pkg::*;
#(
    parameter int STEP_GAP = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              adapt_en,
    input  logic [PCT_W-1:0]  lo_thr,
    input  logic [PCT_W-1:0]  hi_thr,
    input  logic              sample_ok,
    input  logic [PCT_W-1:0]  load_pct,
    input  logic [CODE_W-1:0] sw_code,
    output logic [CODE_W-1:0] hw_code
);
    localparam int GAP_W = (STEP_GAP > 1) ? $clog2(STEP_GAP) : 1;
    localparam logic [GAP_W-1:0]  GAP_FULL = GAP_W'(STEP_GAP - 1);
    localparam logic [CODE_W-1:0] CODE_TOP = '1;

    logic [GAP_W-1:0] gap_cnt;
    logic lo_on, hi_on, order_bad, want_up, want_dn, take_step;

    // Decode threshold validity and the direction a sample asks for.
    always_comb begin
        lo_on     = pct_in_range(lo_thr);
        hi_on     = pct_in_range(hi_thr);
        order_bad = lo_on && hi_on && (lo_thr > hi_thr);
        want_up   = hi_on && (load_pct > hi_thr) && (hw_code != CODE_TOP);
        want_dn   = lo_on && (load_pct < lo_thr) && (hw_code != '0);
        take_step = sample_ok && !order_bad && (gap_cnt == GAP_FULL)
                    && (want_up || want_dn);
    end

    // Code register and spacing counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hw_code <= '0;
            gap_cnt <= GAP_FULL;
        end else if (!adapt_en) begin
            hw_code <= sw_code;
            gap_cnt <= GAP_FULL;
        end else if (take_step) begin
            hw_code <= want_up ? hw_code + 1'b1 : hw_code - 1'b1;
            gap_cnt <= '0;
        end else if (sample_ok && gap_cnt != GAP_FULL) begin
            gap_cnt <= gap_cnt + 1'b1;
        end
    end

    p_single_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (adapt_en && $past(adapt_en) && hw_code != $past(hw_code)) |->
        ((int'(hw_code) - int'($past(hw_code)) == 1) ||
         (int'($past(hw_code)) - int'(hw_code) == 1)));

    p_no_sample_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (adapt_en && !sample_ok) |=> $stable(hw_code));

    p_inverted_freeze_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (adapt_en && pct_in_range(lo_thr) && pct_in_range(hi_thr)
         && lo_thr > hi_thr) |=> $stable(hw_code));

    p_enable_start_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(adapt_en) |-> (hw_code == $past(sw_code)));
endmodule

// File: rtl/peak_code_tuner.sv
// Top of the adaptive peak-current code controller. It joins the
// configuration register, the load latch and the step engine, and forms
// the applied code and the status word.
module peak_code_tuner
    import ptune_pkg::*;
#(
    parameter int STEP_GAP = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [31:0]       cfg_wdata,
    output logic [31:0]       cfg_rdata,
    input  logic [CODE_W-1:0] sw_code,
    input  logic              load_valid,
    input  logic [PCT_W-1:0]  load_pct,
    output logic [31:0]       status_word,
    output logic [CODE_W-1:0] applied_code
);
    tune_cfg_t         cfg;
    logic [PCT_W-1:0]  load_q;
    logic              sample_ok;
    logic [CODE_W-1:0] hw_code;

    ptune_cfg_reg u_cfg (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (cfg_we),
        .wdata (cfg_wdata),
        .cfg   (cfg),
        .rdata (cfg_rdata)
    );

    ptune_load_latch u_load (
        .clk        (clk),
        .rst_n      (rst_n),
        .mtr_en     (cfg.mtr_en),
        .load_valid (load_valid),
        .load_pct   (load_pct),
        .load_q     (load_q),
        .sample_ok  (sample_ok)
    );

    ptune_step_engine #(.STEP_GAP(STEP_GAP)) u_step (
        .clk       (clk),
        .rst_n     (rst_n),
        .adapt_en  (cfg.adapt_en),
        .lo_thr    (cfg.lo_thr),
        .hi_thr    (cfg.hi_thr),
        .sample_ok (sample_ok),
        .load_pct  (load_pct),
        .sw_code   (sw_code),
        .hw_code   (hw_code)
    );

    // Select the code in force and pack the status word.
    always_comb begin
        applied_code = cfg.adapt_en ? hw_code : sw_code;
        status_word  = '0;
        status_word[ST_CODE_LSB +: CODE_W] = applied_code;
        status_word[0 +: PCT_W]            = load_q;
    end

    p_passthrough_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!cfg_rdata[CFG_ADP_BIT]) |-> (status_word[ST_CODE_LSB +: CODE_W] == sw_code));
endmodule

// File: tb/test_peak_code_tuner.sv
// Scoreboard bench: driver tasks push expected results computed from the
// requirements, and a monitor on the falling edge pops and compares them.
module test_peak_code_tuner;
    localparam int GAP = 3;

    logic        clk = 0;
    logic        rst_n = 0;
    logic        cfg_we = 0;
    logic [31:0] cfg_wdata = '0;
    logic [31:0] cfg_rdata;
    logic [2:0]  sw_code = '0;
    logic        load_valid = 0;
    logic [6:0]  load_pct = '0;
    logic [31:0] status_word;
    logic [2:0]  applied_code;

    peak_code_tuner #(.STEP_GAP(GAP)) i_peak_code_tuner (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
        .cfg_rdata(cfg_rdata), .sw_code(sw_code), .load_valid(load_valid),
        .load_pct(load_pct), .status_word(status_word), .applied_code(applied_code)
    );

    always #10 clk = ~clk;

    // Reference state
    logic [31:0] m_cfg = '0;
    logic [2:0]  m_hw = '0;
    int          m_gap = GAP - 1;
    logic [6:0]  m_load = '0;

    logic [31:0] q_st[$];
    logic [31:0] q_cfg[$];
    string       q_tag[$];
    int n_vec = 0;
    int n_bad = 0;
    bit done = 0;

    function automatic bit in_rng(input logic [6:0] v);
        return (v >= 1) && (v <= 100);
    endfunction

    // Advance the reference across one clock edge.
    task automatic model_edge();
        logic [6:0] lo, hi;
        bit smp, lo_on, hi_on, frz, up, dn;
        if (!rst_n) begin
            m_cfg = '0; m_hw = '0; m_gap = GAP - 1; m_load = '0;
            return;
        end
        lo = m_cfg[14:8]; hi = m_cfg[22:16];
        smp = load_valid && m_cfg[0] && in_rng(load_pct);
        if (!m_cfg[4]) begin
            m_hw = sw_code; m_gap = GAP - 1;
        end else if (smp) begin
            lo_on = in_rng(lo); hi_on = in_rng(hi);
            frz = lo_on && hi_on && (lo > hi);
            up = hi_on && (load_pct > hi) && (m_hw != 3'd7);
            dn = lo_on && (load_pct < lo) && (m_hw != 3'd0);
            if (!frz && m_gap == GAP - 1 && (up || dn)) begin
                m_hw = up ? m_hw + 3'd1 : m_hw - 3'd1;
                m_gap = 0;
            end else if (m_gap != GAP - 1) begin
                m_gap++;
            end
        end
        if (load_valid && m_cfg[0]) m_load = load_pct;
        if (cfg_we) m_cfg = cfg_wdata & 32'h007F_7F11;
    endtask

    task automatic tick(input string tag);
        @(posedge clk);
        model_edge();
        #1;
        cfg_we = 0; load_valid = 0;
        q_st.push_back({21'd0, (m_cfg[4] ? m_hw : sw_code), 1'b0, m_load});
        q_cfg.push_back(m_cfg);
        q_tag.push_back(tag);
    endtask

    task automatic do_cfg_raw(input logic [31:0] w, input string tag);
        @(negedge clk); #2;
        cfg_we = 1; cfg_wdata = w;
        tick(tag);
    endtask

    task automatic do_cfg(input bit lm, input bit ad, input int lo, input int hi, input string tag);
        do_cfg_raw({9'd0, 7'(hi), 1'b0, 7'(lo), 3'd0, ad, 3'd0, lm}, tag);
    endtask

    task automatic do_sample(input int pct, input string tag);
        @(negedge clk); #2;
        load_valid = 1; load_pct = 7'(pct);
        tick(tag);
    endtask

    task automatic set_sw(input logic [2:0] c, input string tag);
        @(negedge clk); #2;
        sw_code = c;
        tick(tag);
    endtask

    // Monitor: compare the oldest expectation against the ports.
    always @(negedge clk) begin
        if (q_st.size() != 0) begin
            logic [31:0] es, ec;
            string t;
            es = q_st.pop_front(); ec = q_cfg.pop_front(); t = q_tag.pop_front();
            n_vec++;
            if (status_word !== es || cfg_rdata !== ec || applied_code !== es[10:8]) begin
                n_bad++;
                $display("FAIL %s: status=%h cfg=%h code=%0d expected status=%h cfg=%h code=%0d",
                         t, status_word, cfg_rdata, applied_code, es, ec, es[10:8]);
            end
        end
    end

    initial begin
        #(200000 * 20);
        if (!done) begin
            done = 1;
            n_bad++;
            $display("FAIL watchdog: run did not complete, expected end of sequence");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        tick("R1 R2 reset");
        tick("R1 R2 reset");
        @(negedge clk); #2; rst_n = 1;
        tick("R1 R2 after reset");
        do_cfg_raw(32'hFF80_80EE, "R1 unused bits dropped");
        do_cfg_raw(32'hFFFF_FFFF, "R1 all fields set");
        do_cfg(0, 0, 0, 0, "R1 clear");
        set_sw(3'd5, "R4 passthrough");
        do_sample(50, "R3 meter off ignores reading");
        do_cfg(1, 0, 0, 0, "R1 meter on");
        do_sample(42, "R3 R2 reading latched");
        set_sw(3'd2, "R4 passthrough follows");
        do_sample(120, "R10 R3 out-of-range reading latched");
        set_sw(3'd3, "R4 passthrough");
        do_cfg(1, 1, 30, 70, "R8 adaptive start from software code");
        for (int i = 0; i < 4; i++) do_sample(80, "R5 R9 R11 step up with spacing");
        for (int i = 0; i < 14; i++) do_sample(90, "R5 saturate at 7");
        for (int i = 0; i < 3; i++) do_sample(50, "R5 hold between thresholds");
        for (int i = 0; i < 26; i++) do_sample(10, "R5 step down and saturate at 0");
        for (int i = 0; i < 3; i++) do_sample(95, "R5 climb again");
        do_sample(0, "R10 zero reading no step");
        do_sample(127, "R10 invalid reading no step");
        for (int i = 0; i < 3; i++) do_sample(95, "R10 R9 spacing not advanced by invalid");
        do_cfg(1, 1, 30, 0, "R6 high threshold zero");
        for (int i = 0; i < 4; i++) do_sample(99, "R6 upward compare off");
        do_cfg(1, 1, 30, 110, "R6 high threshold above 100");
        for (int i = 0; i < 4; i++) do_sample(99, "R6 upward compare off");
        for (int i = 0; i < 4; i++) do_sample(5, "R6 downward compare still on");
        do_cfg(1, 1, 0, 70, "R6 low threshold zero");
        for (int i = 0; i < 4; i++) do_sample(1, "R6 downward compare off");
        for (int i = 0; i < 4; i++) do_sample(90, "R6 upward compare still on");
        do_cfg(1, 1, 101, 70, "R6 low threshold above 100");
        for (int i = 0; i < 4; i++) do_sample(1, "R6 downward compare off");
        do_cfg(1, 1, 80, 20, "R7 inverted thresholds");
        for (int i = 0; i < 4; i++) do_sample(10, "R7 frozen low load");
        for (int i = 0; i < 4; i++) do_sample(90, "R7 frozen high load");
        do_cfg(1, 0, 30, 70, "R4 adaptive off");
        set_sw(3'd6, "R4 passthrough");
        do_cfg(1, 1, 30, 70, "R8 restart from software code");
        do_sample(10, "R11 first sample steps at once");
        do_sample(10, "R9 blocked after step");
        do_cfg(0, 1, 30, 70, "R3 meter off in adaptive");
        for (int i = 0; i < 4; i++) do_sample(10, "R3 R10 meter off no step");
        @(negedge clk); @(negedge clk);
        if (!done) begin
            done = 1;
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end
endmodule